// File: doc/BRIEF.md
# Backlight PWM with power-of-two prescaler

A single-channel pulse-width generator meant to drive a display backlight. Each period is split into 256 steps of an 8-bit counter. A power-of-two prescaler stretches each step to 1, 2, 4 and so on up to 64 ticks of the counting source. The output holds its active level while the counter is below an 8-bit compare value. Because the compare value tops out at 255, the duty can be anything from 0/256 to 255/256, and a fully-on output cannot be programmed.

The counting source is picked by a select register. It is either a slow tick input, used as a clock enable inside the single clock domain, or every cycle of the system clock. A configuration word carries the compare value, a polarity bit and the prescaler code. While the channel runs, this word is held in shadow storage and takes effect only at a period boundary, so no period is ever cut short or mixed. Software starts and stops the channel with separate write-one strobes. A status output follows each strobe after a fixed two-cycle lag, so polling it tells software that the action has taken effect.

Top module: `bl_pwm`

## Requirements
- R1: After reset the channel is stopped (`running` = 0), the select, compare, polarity and prescaler fields are all 0, and `pwm_out` is 1, which is the inactive level for polarity 0.
- R2: A cycle with `en_we`=1 and `en_wdata`=1 (and no disable strobe) makes `running` read 1 after the second following clock edge and not before. A write of `en_wdata`=0 has no effect.
- R3: A cycle with `dis_we`=1 and `dis_wdata`=1 makes `running` read 0 after the second following clock edge. A write of 0 has no effect. When both strobes arrive in the same cycle, the disable wins.
- R4: One period lasts 256·2^P counting-source ticks, where P is the prescaler code in configuration bits 2:0. Codes 0 to 6 are legal, and code 7 behaves as 6.
- R5: With compare value C in configuration bits 15:8, the output is active for the first C·2^P ticks of each period. C=0 keeps the output inactive for the whole period, and C=255 gives 255/256 duty.
- R6: Configuration bit 4 is the polarity. When it is 1 the active level is high; when it is 0 the active level is low and the inactive level is high.
- R7: Bit 0 of the select register (`sel_wdata`) picks the counting source: 0 counts cycles with `slow_tick`=1, and 1 counts every system clock cycle.
- R8: While running, a configuration write changes nothing in the current period and takes effect from the next period boundary.
- R9: While stopped, `pwm_out` holds the inactive level of the most recently written polarity bit, one cycle after the write.
- R10: An enable that takes effect restarts the period from count zero, so the active portion begins at once, even if the channel was already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow timebase, one-cycle pulses used as a count enable |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word: compare [15:8], polarity [4], prescaler [2:0] |
| sel_we | input | 1 | Write strobe for the source select register |
| sel_wdata | input | 1 | Source select: 0 slow tick, 1 system clock |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 1 | Enable bit, acts only when 1 |
| dis_we | input | 1 | Write strobe for the disable register |
| dis_wdata | input | 1 | Disable bit, acts only when 1 |
| running | output | 1 | Channel status |
| pwm_out | output | 1 | Backlight drive output |

## Verification
The bench builds the block with its default parameters: an 8-bit compare and a prescaler capped at 6. With these values even the longest period, 16384 system cycles when counting on the system clock, fits several times into one run. This lets the clamped code 7 be measured over a whole period, next to short prescaler-0 periods in which shadow updates and restarts land at known counts. A slow tick with a fixed 1-in-4 spacing makes the period length on that source exact, so high-time counts over one period window can be predicted exactly.

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int CMP_W  = 8,
  parameter int PS_W   = 3,
  parameter int PS_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              cfg_we,
  input  logic [CMP_W+7:0]  cfg_wdata,
  input  logic              sel_we,
  input  logic              sel_wdata,
  input  logic              en_we,
  input  logic              en_wdata,
  input  logic              dis_we,
  input  logic              dis_wdata,
  output logic              running,
  output logic              pwm_out
);
  localparam int PRE_W = (PS_MAX > 0) ? PS_MAX : 1;

  logic [CMP_W-1:0] cmp_sh, cmp_a, cnt;
  logic [PS_W-1:0]  ps_sh, ps_a, ps_in, ps_cl;
  logic             pol_sh, pol_a, src_sys;
  logic [PRE_W-1:0] pre, pre_lim;
  logic             pend_v, pend_on, run;
  logic             en_hit, dis_hit, tick, pre_wrap, boundary, restart, load;

  assign en_hit   = en_we & en_wdata;
  assign dis_hit  = dis_we & dis_wdata;
  assign ps_in    = cfg_wdata[PS_W-1:0];
  assign ps_cl    = (int'(ps_in) > PS_MAX) ? PS_W'(PS_MAX) : ps_in;
  assign tick     = src_sys | slow_tick;
  assign pre_lim  = PRE_W'((1 << ps_a) - 1);
  assign pre_wrap = (pre == pre_lim);
  assign boundary = run & tick & pre_wrap & (&cnt);
  assign restart  = pend_v & pend_on;
  assign load     = ~run | restart | boundary;
  assign running  = run;
  assign pwm_out  = (run && cnt < cmp_a) ? pol_a : ~pol_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_sh <= '0; pol_sh <= 1'b0; ps_sh <= '0; src_sys <= 1'b0;
      cmp_a  <= '0; pol_a  <= 1'b0; ps_a  <= '0;
      pre <= '0; cnt <= '0; run <= 1'b0; pend_v <= 1'b0; pend_on <= 1'b0;
    end else begin
      if (cfg_we) begin
        cmp_sh <= cfg_wdata[CMP_W+7:8];
        pol_sh <= cfg_wdata[4];
        ps_sh  <= ps_cl;
      end
      if (sel_we) src_sys <= sel_wdata;
      pend_v  <= en_hit | dis_hit;
      pend_on <= en_hit & ~dis_hit;
      if (run && tick) begin
        if (pre_wrap) begin
          pre <= '0;
          cnt <= cnt + 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
      end
      if (pend_v) begin
        run <= pend_on;
        if (pend_on) begin
          pre <= '0;
          cnt <= '0;
        end
      end
      if (load) begin
        cmp_a <= cmp_sh;
        pol_a <= pol_sh;
        ps_a  <= ps_sh;
      end
    end
  end

  assert_enable_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_hit, 2) && !$past(dis_hit, 2) && !$past(dis_hit) |-> running)
    else $error("enable did not show on status");

  assert_disable_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_hit, 2) |-> !running)
    else $error("disable did not show on status");

  assert_legal_prescale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (int'(ps_a) <= PS_MAX && pre <= pre_lim))
    else $error("prescaler out of range");

  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running && cmp_a == '0 |-> pwm_out != pol_a)
    else $error("zero compare drove active level");

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && cnt != '0 |-> $stable(cmp_a) && $stable(pol_a) && $stable(ps_a))
    else $error("settings changed inside a period");
endmodule

// File: tb/sim_bl_pwm.sv
module sim_bl_pwm;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0;
  logic cfg_we = 1'b0, sel_we = 1'b0, sel_wdata = 1'b0;
  logic en_we = 1'b0, en_wdata = 1'b0, dis_we = 1'b0, dis_wdata = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic running, pwm_out;

  int total = 0, bad = 0, tick_div = 0;
  string phase = "R1";

  bl_pwm u0 (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .sel_we(sel_we), .sel_wdata(sel_wdata), .en_we(en_we),
    .en_wdata(en_wdata), .dis_we(dis_we), .dis_wdata(dis_wdata),
    .running(running), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_div  <= (tick_div + 1) % 4;
    slow_tick <= (tick_div == 3);
  end

  int m_cmp_sh, m_pol_sh, m_ps_sh, m_sel, m_cmp, m_pol, m_ps, m_pos, m_pend;
  bit m_run;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp_sh = 0; m_pol_sh = 0; m_ps_sh = 0; m_sel = 0;
      m_cmp = 0; m_pol = 0; m_ps = 0; m_pos = 0; m_pend = 0; m_run = 0;
    end else begin
      bit wrapped;
      wrapped = 0;
      if (m_run && (m_sel == 1 || slow_tick)) begin
        m_pos++;
        if (m_pos == (256 << m_ps)) begin m_pos = 0; wrapped = 1; end
      end
      if (!m_run || m_pend == 1 || wrapped) begin
        m_cmp = m_cmp_sh; m_pol = m_pol_sh; m_ps = m_ps_sh;
      end
      if (m_pend == 1) begin m_run = 1; m_pos = 0; end
      else if (m_pend == 2) m_run = 0;
      m_pend = (dis_we && dis_wdata) ? 2 : (en_we && en_wdata) ? 1 : 0;
      if (cfg_we) begin
        m_cmp_sh = cfg_wdata[15:8];
        m_pol_sh = cfg_wdata[4];
        m_ps_sh  = (cfg_wdata[2:0] > 6) ? 6 : cfg_wdata[2:0];
      end
      if (sel_we) m_sel = sel_wdata;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int exp_out;
    exp_out = m_run ? (((m_pos >> m_ps) < m_cmp) ? m_pol : !m_pol) : !m_pol;
    chk({phase, " pwm_out"}, pwm_out, exp_out);
    chk({phase, " running"}, running, m_run);
  end

  task automatic wr_cfg(int cmp, int pol, int ps);
    @(negedge clk); cfg_we = 1; cfg_wdata = {8'(cmp), 3'b0, 1'(pol), 1'b0, 3'(ps)};
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_sel(bit v);
    @(negedge clk); sel_we = 1; sel_wdata = v;
    @(negedge clk); sel_we = 0;
  endtask

  task automatic strobe(bit en, bit ev, bit dis, bit dv);
    @(negedge clk); en_we = en; en_wdata = ev; dis_we = dis; dis_wdata = dv;
    @(negedge clk); en_we = 0; en_wdata = 0; dis_we = 0; dis_wdata = 0;
  endtask

  task automatic count_high(int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += pwm_out; end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int h;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset running", running, 0);
    chk("R1 reset pwm_out", pwm_out, 1);

    phase = "R2";
    wr_sel(1);
    wr_cfg(64, 1, 0);
    strobe(1, 0, 0, 0);
    wait_cyc(3);
    chk("R2 zero write ignored", running, 0);
    strobe(1, 1, 0, 0);
    chk("R2 status one edge after", running, 0);
    @(negedge clk);
    chk("R2 status two edges after", running, 1);
    chk("R10 active at once", pwm_out, 1);

    phase = "R5";
    count_high(256, h);
    chk("R5 duty 64/256", h, 64);

    phase = "R8";
    wait_cyc(28);
    wr_cfg(10, 1, 0);
    wait_cyc(5);
    chk("R8 old compare holds", pwm_out, 1);
    wait_cyc(256 - 37 + 30);
    chk("R8 new compare applied", pwm_out, 0);

    phase = "R10";
    wr_cfg(64, 1, 0);
    wait_cyc(300);
    strobe(1, 1, 0, 0);
    @(negedge clk);
    chk("R10 restart active", pwm_out, 1);
    wait_cyc(30);
    chk("R10 restart count from zero", pwm_out, 1);

    phase = "R6";
    wr_cfg(64, 0, 0);
    wait_cyc(300);
    count_high(256, h);
    chk("R6 low-active duty", h, 192);

    phase = "R5";
    wr_cfg(0, 1, 0);
    wait_cyc(300);
    count_high(256, h);
    chk("R5 zero compare", h, 0);
    wr_cfg(255, 1, 0);
    wait_cyc(300);
    count_high(256, h);
    chk("R5 max compare", h, 255);

    phase = "R7";
    wr_cfg(128, 1, 0);
    wr_sel(0);
    wait_cyc(1400);
    count_high(1024, h);
    chk("R7 slow source window", h, 512);
    wr_sel(1);

    phase = "R4";
    wr_cfg(128, 1, 7);
    wait_cyc(16384 + 1200);
    count_high(16384, h);
    chk("R4 prescale 7 as 6", h, 8192);
    wr_cfg(32, 1, 2);
    wait_cyc(16384 + 1100);
    count_high(1024, h);
    chk("R4 prescale 2", h, 128);

    phase = "R3";
    strobe(0, 0, 1, 0);
    wait_cyc(3);
    chk("R3 zero write ignored", running, 1);
    strobe(0, 0, 1, 1);
    @(negedge clk);
    chk("R3 stopped after two edges", running, 0);

    phase = "R9";
    chk("R9 idle level pol1", pwm_out, 0);
    wr_cfg(32, 0, 0);
    @(negedge clk);
    chk("R9 idle level pol0", pwm_out, 1);

    phase = "R3";
    strobe(1, 1, 1, 1);
    wait_cyc(3);
    chk("R3 disable wins", running, 0);

    finish_run();
  end
endmodule